// File: doc/BRIEF.md
# Tick Counter With Compare

This block keeps a free-running counter that advances by one on every cycle where a tick enable is high. Software can load the counter and set a compare limit through a simple write port, and it can read both back at any time. The top bit of each 64-bit word is a control flag rather than data. On the counter word it is a non-privileged-access marker, which is stored and returned but not enforced. On the limit word it is an interrupt-disable flag.

When the counter steps onto the limit value, the block raises a one-cycle match pulse. The same pulse also drives a one-hot set request toward a software-interrupt register, at a bit position chosen per instance. A typical use places two instances side by side: one as the ordinary tick timer, setting bit 0, and one as the system tick timer, setting bit 16. A limit of zero, or a limit written with its disable flag set, never produces a match. Once a match has fired, the compare stays quiet until software writes a new limit or the counter wraps around.

Top module: `tick_compare_timer`

## Requirements
- R1: A counter write (cntWrEn) loads wrData[62:0] as the counter value and wrData[63] as the access flag. cntRdData returns {flag, counter}, with the new value visible in the cycle after the write edge.
- R2: The counter increments by one at each clock edge where tickEn is high. A counter write at the same edge wins, and the written value is loaded without an increment.
- R3: A limit write (limWrEn) stores wrData[62:0] as the compare value and wrData[63] as the disable flag. limRdData returns {disable, compare}.
- R4: When an increment makes the counter equal to a nonzero, enabled, armed compare value, matchPulse is high for exactly the one cycle in which the counter first reads that value.
- R5: A compare value of zero never produces a match, including when the counter wraps to zero.
- R6: While the disable flag is 1, no match pulse is produced.
- R7: After a match, the compare is re-armed only by a limit write or by the counter wrapping from all ones to zero. A counter write does not re-arm it, and a counter write that loads the limit value does not match.
- R8: softintSet is all zero except bit SET_BIT, which equals matchPulse (default SET_BIT = 0, SOFTINT_W = 17).
- R9: Reset clears the counter, both flags and the compare value, and leaves the compare disarmed. No pulse occurs until a limit is written.
- R10: The counter wraps from 2^63-1 to 0 on an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable for this cycle |
| cntWrEn | input | 1 | Load counter word from wrData |
| limWrEn | input | 1 | Load limit word from wrData |
| wrData | input | 64 | Write data; bit 63 is the control flag |
| cntRdData | output | 64 | {access flag, counter} |
| limRdData | output | 64 | {disable flag, compare value} |
| matchPulse | output | 1 | One-cycle compare match |
| softintSet | output | 17 | One-hot set request for the software-interrupt register |

## Verification
Every result here is one register stage after its cause. A write or an increment at a rising edge shows on the read ports from the following falling edge. The match pulse is registered on that same edge, so it is high in exactly the cycle where the counter first reads the limit. The bench drives all inputs on falling edges and samples the outputs at the next falling edge, which is one edge after the cause. It counts pulses over each tick run and records the counter value and interrupt-set vector seen while the pulse was high. This confirms both the cycle of the pulse and that it appears only once.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
  // Strobes sent from the control unit to the datapath each cycle.
  typedef struct packed {
    logic loadCnt;   // replace counter and access flag
    logic incCnt;    // advance counter by one
    logic loadLim;   // replace compare value and disable flag
  } ctrlStrobe_t;

  // Status returned from the datapath to the control unit.
  typedef struct packed {
    logic nextEqLim; // counter + 1 equals the compare value
    logic cntAllOnes;// counter is at its maximum
    logic limZero;   // compare value is zero
    logic limDis;    // disable flag
  } dpStatus_t;
endpackage

// File: rtl/tick_cmp_datapath.sv
module tick_cmp_datapath
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W = 63,
  localparam int DATA_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntWord,
  output logic [DATA_W-1:0] limWord,
  output dpStatus_t         status
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limQ;
  logic             nptQ;
  logic             disQ;
  logic [CNT_W-1:0] cntPlusOne;

  assign cntPlusOne = cntQ + CNT_W'(1);

  // Counter: a load wins over an increment.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      nptQ <= 1'b0;
    end else if (strobe.loadCnt) begin
      cntQ <= wrData[CNT_W-1:0];
      nptQ <= wrData[DATA_W-1];
    end else if (strobe.incCnt) begin
      cntQ <= cntPlusOne;
    end
  end

  // Compare register and its disable flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limQ <= '0;
      disQ <= 1'b0;
    end else if (strobe.loadLim) begin
      limQ <= wrData[CNT_W-1:0];
      disQ <= wrData[DATA_W-1];
    end
  end

  always_comb begin
    status.nextEqLim  = (cntPlusOne == limQ);
    status.cntAllOnes = &cntQ;
    status.limZero    = (limQ == '0);
    status.limDis     = disQ;
  end

  assign cntWord = {nptQ, cntQ};
  assign limWord = {disQ, limQ};
endmodule

// File: rtl/tick_cmp_control.sv
module tick_cmp_control
  import tick_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        cntWrEn,
  input  logic        limWrEn,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        matchQ
);
  logic armedQ;
  logic hit;
  logic wrapNow;

  always_comb begin
    strobe.loadCnt = cntWrEn;
    strobe.incCnt  = tickEn & ~cntWrEn;
    strobe.loadLim = limWrEn;
  end

  // A match needs a real increment onto an armed, nonzero, enabled limit.
  // A limit write at the same edge replaces the compare, so it suppresses.
  assign hit = strobe.incCnt & ~limWrEn & armedQ & status.nextEqLim
             & ~status.limZero & ~status.limDis;
  assign wrapNow = strobe.incCnt & status.cntAllOnes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      matchQ <= 1'b0;
    end else begin
      matchQ <= hit;
      if (limWrEn)      armedQ <= 1'b1;
      else if (hit)     armedQ <= 1'b0;
      else if (wrapNow) armedQ <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W     = 63,
  parameter int SOFTINT_W = 17,
  parameter int SET_BIT   = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 cntWrEn,
  input  logic                 limWrEn,
  input  logic [CNT_W:0]       wrData,
  output logic [CNT_W:0]       cntRdData,
  output logic [CNT_W:0]       limRdData,
  output logic                 matchPulse,
  output logic [SOFTINT_W-1:0] softintSet
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        matchQ;

  tick_cmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .cntWord (cntRdData),
    .limWord (limRdData),
    .status  (status)
  );

  tick_cmp_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .cntWrEn (cntWrEn),
    .limWrEn (limWrEn),
    .status  (status),
    .strobe  (strobe),
    .matchQ  (matchQ)
  );

  assign matchPulse = matchQ;

  // Interrupt set request: only the selected bit carries the pulse.
  for (genvar g = 0; g < SOFTINT_W; g++) begin : g_si
    if (g == SET_BIT) begin : g_on
      assign softintSet[g] = matchQ;
    end else begin : g_off
      assign softintSet[g] = 1'b0;
    end
  end
endmodule

// File: rtl/tick_compare_timer_checker.sv
module tick_compare_timer_checker #(
  parameter int CNT_W     = 63,
  parameter int SOFTINT_W = 17,
  parameter int SET_BIT   = 0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic                 cntWrEn,
  input logic                 limWrEn,
  input logic [CNT_W:0]       wrData,
  input logic [CNT_W:0]       cntRdData,
  input logic [CNT_W:0]       limRdData,
  input logic                 matchPulse,
  input logic [SOFTINT_W-1:0] softintSet
);
  a_r1_load: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWrEn) && $past(rstN) |-> cntRdData == $past(wrData));

  a_r2_inc: assert property (@(posedge clk) disable iff (!rstN)
    $past(tickEn) && !$past(cntWrEn) && $past(rstN)
      |-> cntRdData[CNT_W-1:0] == $past(cntRdData[CNT_W-1:0]) + CNT_W'(1));

  a_r4_equal: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> cntRdData[CNT_W-1:0] == limRdData[CNT_W-1:0]);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse && !limWrEn |=> !matchPulse);

  a_r5_zero_limit: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> limRdData[CNT_W-1:0] != '0);

  a_r6_disabled: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> !limRdData[CNT_W]);

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(softintSet) && (softintSet[SET_BIT] == matchPulse));
endmodule

bind tick_compare_timer tick_compare_timer_checker #(
  .CNT_W(CNT_W), .SOFTINT_W(SOFTINT_W), .SET_BIT(SET_BIT)
) u_chk (.*);

// File: tb/sim_tick_compare_timer.sv
module sim_tick_compare_timer;
  localparam logic [62:0] ALL1 = {63{1'b1}};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        cntWrEn = 1'b0;
  logic        limWrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] cntRdData, limRdData;
  logic        matchPulse;
  logic [16:0] softintSet;

  int nChecks = 0;
  int nFails  = 0;
  int pulses;
  logic [62:0] hitVal;
  logic [16:0] hitSi;

  always #5 clk = ~clk;

  tick_compare_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntWrEn(cntWrEn),
    .limWrEn(limWrEn), .wrData(wrData), .cntRdData(cntRdData),
    .limRdData(limRdData), .matchPulse(matchPulse), .softintSet(softintSet)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrCnt(logic [63:0] v, logic alsoTick = 1'b0);
    @(negedge clk);
    wrData = v; cntWrEn = 1'b1; tickEn = alsoTick;
    @(negedge clk);
    cntWrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic wrLim(logic [63:0] v);
    @(negedge clk);
    wrData = v; limWrEn = 1'b1;
    @(negedge clk);
    limWrEn = 1'b0;
  endtask

  // Tick n times; record pulse count and counter/interrupt state at the pulse.
  task automatic ticks(int n);
    pulses = 0; hitVal = '0; hitSi = '0;
    @(negedge clk);
    tickEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (matchPulse) begin
        pulses++; hitVal = cntRdData[62:0]; hitSi = softintSet;
      end
    end
    tickEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    check("R9 count after reset", cntRdData, 64'h0);
    check("R9 limit after reset", limRdData, 64'h0);
    check("R9 pulse after reset", {63'h0, matchPulse}, 64'h0);
    ticks(10);
    check("R9 no pulse before limit write", pulses, 0);
    check("R2 count after 10 ticks", cntRdData, 64'd10);
  endtask

  task automatic testWrites();
    wrCnt({1'b1, 63'h123});
    check("R1 count word readback", cntRdData, 64'h8000_0000_0000_0123);
    wrCnt(64'h0000_0000_0000_0777, 1'b1);
    check("R2 write beats increment", cntRdData, 64'h777);
    wrLim({1'b1, 63'h4321});
    check("R3 limit word readback", limRdData, 64'h8000_0000_0000_4321);
  endtask

  task automatic testMatch();
    wrLim(64'd20);
    wrCnt(64'd10);
    ticks(15);
    check("R4 one pulse", pulses, 1);
    check("R4 pulse at limit", {1'b0, hitVal}, 64'd20);
    check("R8 interrupt set bit", {47'h0, hitSi}, 64'h1);
    check("R8 idle interrupt set", {47'h0, softintSet}, 64'h0);
  endtask

  task automatic testRearm();
    wrCnt(64'd15);
    ticks(10);
    check("R7 count write does not re-arm", pulses, 0);
    wrCnt({1'b0, 63'd20});
    ticks(3);
    check("R7 loading limit value does not match", pulses, 0);
    wrCnt({1'b0, ALL1 - 63'd2});
    ticks(25);
    check("R7 wrap re-arms", pulses, 1);
    check("R10 count after wrap", cntRdData, 64'd22);
    wrCnt(64'd30);
    wrLim(64'd40);
    ticks(15);
    check("R7 limit write re-arms", pulses, 1);
    check("R4 second pulse value", {1'b0, hitVal}, 64'd40);
  endtask

  task automatic testSuppress();
    wrLim({1'b1, 63'd20});
    wrCnt(64'd0);
    ticks(30);
    check("R6 disabled limit silent", pulses, 0);
    wrLim(64'd0);
    wrCnt({1'b0, ALL1 - 63'd3});
    ticks(10);
    check("R5 zero limit silent", pulses, 0);
    check("R10 wrapped count", cntRdData, 64'd6);
  endtask

  task automatic testResetMidRun();
    wrLim(64'd50);
    wrCnt(64'd45);
    doReset();
    check("R9 count cleared", cntRdData, 64'h0);
    check("R9 limit cleared", limRdData, 64'h0);
    ticks(60);
    check("R9 compare cancelled", pulses, 0);
  endtask

  initial begin
    testReset();
    testWrites();
    testMatch();
    testRearm();
    testSuppress();
    testResetMidRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule